// File: doc/BRIEF.md
# Pulse-Driven Trim Programming Controller

This block is the sequencer behind a one-time-programmable trim scheme. Three single-cycle pulse events arrive from a level detector on a shared pin: a mid pulse, a high pulse and a blow pulse. A high pulse opens a selection window. Mid pulses then count a key, and a second high pulse picks the parameter register that the key names. Further mid pulses raise a temporary try code in that register. A third high pulse arms the blow stage, where a blow pulse asks the fuse array to burn the single addressed bit.

The fuse array is external to this block. It drives its sticky bits in as inputs and takes a request/acknowledge pair. The block presents the effective trim words, which are the fuse bits ORed with the live try code. It also reports the permanent lock fuse. A reset stands for a supply cycle: it drops every try value and every bit of sequencer state, but the fuse inputs are not affected by it.

Top module: `trim_prog_ctrl`

## Requirements
- R1: After reset, `phase_o` is 0 (idle), `blow_req_o` and `blow_err_o` are 0, and the trim outputs equal the fuse inputs.
- R2: In idle (phase 0), mid and blow pulses have no effect. A high pulse moves the block to key counting (phase 1) with the key cleared.
- R3: In phase 1, each mid pulse raises the key, saturating at 7. On a high pulse, key 1 targets the sensitivity register, key 2 targets the auxiliary register, and the block enters addressing (phase 2) with the try code at 0. Any other key returns the block to phase 0 and targets nothing.
- R4: In phase 2, each mid pulse raises the 6-bit try code by one, saturating at 63. A high pulse moves the block to the armed state (phase 3).
- R5: `sens_trim_o` equals `fuse_sens_i` ORed with the try code when the sensitivity register is targeted. `qout_trim_o` equals bits 4:0 of `fuse_aux_i` ORed with the try code when the auxiliary register is targeted. A try code stays applied until reset, and fuse bits accumulate across resets.
- R6: In phase 3, mid and high pulses have no effect. A blow pulse with exactly one bit set in the try code enters phase 4. In phase 4, `blow_req_o` is 1, `blow_reg_o` is 0 for sensitivity or 1 for auxiliary, and `blow_bit_o` gives the bit index. These outputs hold until `blow_ack_i` is sampled, and the block then enters phase 5.
- R7: A blow pulse in phase 3 with zero bits or more than one bit set in the try code raises no request. It sets `blow_err_o` and enters phase 5.
- R8: Phase 5 ignores every pulse until reset.
- R9: `lock_o` equals bit 5 of `fuse_aux_i`. While it is 1, every pulse in phases 0 to 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; stands for a supply cycle |
| mid_i | input | 1 | Mid pulse event, one cycle |
| high_i | input | 1 | High pulse event, one cycle |
| blow_i | input | 1 | Blow pulse event, one cycle |
| fuse_sens_i | input | 6 | Sticky fuse bits of the sensitivity register |
| fuse_aux_i | input | 6 | Sticky fuse bits of the auxiliary register; bit 5 is the lock fuse |
| blow_ack_i | input | 1 | Fuse array has burned the requested bit |
| blow_req_o | output | 1 | Request to burn one fuse |
| blow_reg_o | output | 1 | Register of the requested fuse (0 sensitivity, 1 auxiliary) |
| blow_bit_o | output | 3 | Bit index of the requested fuse |
| sens_trim_o | output | 6 | Effective sensitivity trim |
| qout_trim_o | output | 5 | Effective quiescent-output trim |
| lock_o | output | 1 | Lock fuse state |
| blow_err_o | output | 1 | A blow was refused because the code was not a single bit |
| phase_o | output | 3 | Sequencer phase (0 idle, 1 key, 2 addressing, 3 armed, 4 request, 5 done) |

## Verification
A pulse is sampled on one rising edge, and the phase, key, code and error registers change on that same edge. The trim, request and phase outputs are decoded from those registers without a further stage, so each result is due one edge after its pulse. A change on the fuse inputs shows on the trim and lock outputs within the same cycle, with no edge in between. The bench drives inputs on falling edges and compares a behavioural model against every output 2 ns after each rising edge. The directed checks sample at the falling edge that follows a pulse, so every expected value is settled before it is read.

// File: rtl/trim_prog_pkg.sv
package trim_prog_pkg;
  typedef enum logic [2:0] {
    PH_INIT = 3'd0,
    PH_SEL  = 3'd1,
    PH_ADDR = 3'd2,
    PH_ARM  = 3'd3,
    PH_REQ  = 3'd4,
    PH_DONE = 3'd5
  } phase_e;

  typedef enum logic {
    TGT_SENS = 1'b0,
    TGT_AUX  = 1'b1
  } tgt_e;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MaxVal = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != MaxVal) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/onehot_index.sv
module onehot_index #(
  parameter int W  = 6,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          single_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign single_o = (vec_i != '0) && ((vec_i & (vec_i - 1'b1)) == '0);
endmodule

// File: rtl/trim_overlay.sv
module trim_overlay #(
  parameter int W = 6
) (
  input  logic [W-1:0] fuse_i,
  input  logic [W-1:0] try_i,
  input  logic         apply_i,
  output logic [W-1:0] eff_o
);
  assign eff_o = fuse_i | (apply_i ? try_i : '0);
endmodule

// File: rtl/trim_prog_ctrl.sv
module trim_prog_ctrl
  import trim_prog_pkg::*;
#(
  parameter int FIELD_W = 6,
  parameter int KEY_W   = 3,
  localparam int IDX_W  = $clog2(FIELD_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mid_i,
  input  logic               high_i,
  input  logic               blow_i,
  input  logic [FIELD_W-1:0] fuse_sens_i,
  input  logic [FIELD_W-1:0] fuse_aux_i,
  input  logic               blow_ack_i,
  output logic               blow_req_o,
  output logic               blow_reg_o,
  output logic [IDX_W-1:0]   blow_bit_o,
  output logic [FIELD_W-1:0] sens_trim_o,
  output logic [FIELD_W-2:0] qout_trim_o,
  output logic               lock_o,
  output logic               blow_err_o,
  output logic [2:0]         phase_o
);
  localparam logic [KEY_W-1:0] KeySens = KEY_W'(1);
  localparam logic [KEY_W-1:0] KeyAux  = KEY_W'(2);

  phase_e phase_q, phase_d;
  tgt_e   tgt_q, tgt_d;
  logic   has_try_q, has_try_d;
  logic   err_q, err_d;
  logic   key_clr, key_inc, code_clr, code_inc;
  logic   locked, single;
  logic [KEY_W-1:0]   key;
  logic [FIELD_W-1:0] code;

  assign locked = fuse_aux_i[FIELD_W-1];

  sat_counter #(.W(KEY_W)) u_key_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(key_clr), .inc_i(key_inc), .cnt_o(key)
  );

  sat_counter #(.W(FIELD_W)) u_code_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(code_clr), .inc_i(code_inc), .cnt_o(code)
  );

  onehot_index #(.W(FIELD_W), .IW(IDX_W)) u_bit_idx (
    .vec_i(code), .idx_o(blow_bit_o), .single_o(single)
  );

  always_comb begin
    phase_d   = phase_q;
    tgt_d     = tgt_q;
    has_try_d = has_try_q;
    err_d     = err_q;
    key_clr   = 1'b0;
    key_inc   = 1'b0;
    code_clr  = 1'b0;
    code_inc  = 1'b0;
    unique case (phase_q)
      PH_INIT: if (!locked && high_i) begin
        phase_d = PH_SEL;
        key_clr = 1'b1;
      end
      PH_SEL: if (!locked) begin
        if (high_i) begin
          if (key == KeySens || key == KeyAux) begin
            phase_d   = PH_ADDR;
            tgt_d     = (key == KeySens) ? TGT_SENS : TGT_AUX;
            has_try_d = 1'b1;
            code_clr  = 1'b1;
          end else begin
            phase_d = PH_INIT;
          end
        end else if (mid_i) begin
          key_inc = 1'b1;
        end
      end
      PH_ADDR: if (!locked) begin
        if (high_i)     phase_d  = PH_ARM;
        else if (mid_i) code_inc = 1'b1;
      end
      PH_ARM: if (!locked && blow_i) begin
        if (single) begin
          phase_d = PH_REQ;
        end else begin
          err_d   = 1'b1;
          phase_d = PH_DONE;
        end
      end
      PH_REQ: if (blow_ack_i) phase_d = PH_DONE;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_INIT;
      tgt_q     <= TGT_SENS;
      has_try_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      tgt_q     <= tgt_d;
      has_try_q <= has_try_d;
      err_q     <= err_d;
    end
  end

  trim_overlay #(.W(FIELD_W)) u_sens_ovl (
    .fuse_i (fuse_sens_i),
    .try_i  (code),
    .apply_i(has_try_q && tgt_q == TGT_SENS),
    .eff_o  (sens_trim_o)
  );

  trim_overlay #(.W(FIELD_W-1)) u_qout_ovl (
    .fuse_i (fuse_aux_i[FIELD_W-2:0]),
    .try_i  (code[FIELD_W-2:0]),
    .apply_i(has_try_q && tgt_q == TGT_AUX),
    .eff_o  (qout_trim_o)
  );

  assign blow_req_o = (phase_q == PH_REQ);
  assign blow_reg_o = tgt_q;
  assign lock_o     = locked;
  assign blow_err_o = err_q;
  assign phase_o    = phase_q;
endmodule

// File: rtl/trim_prog_ctrl_chk.sv
module trim_prog_ctrl_chk
  import trim_prog_pkg::*;
#(
  parameter int FIELD_W = 6,
  parameter int IDX_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               high_i,
  input logic               blow_ack_i,
  input logic [FIELD_W-1:0] fuse_sens_i,
  input logic [FIELD_W-1:0] sens_trim_o,
  input logic               blow_req_o,
  input logic [IDX_W-1:0]   blow_bit_o,
  input logic               blow_err_o,
  input logic               lock_o,
  input logic [2:0]         phase_o
);
  assert_idle_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_INIT && !high_i) |=> phase_o == PH_INIT);

  assert_idle_no_try_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_INIT) |-> sens_trim_o == fuse_sens_i);

  assert_req_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blow_req_o && !blow_ack_i) |=> (blow_req_o && $stable(blow_bit_o)));

  assert_req_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blow_req_o && blow_ack_i) |=> phase_o == PH_DONE);

  assert_err_final_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blow_err_o |-> (phase_o == PH_DONE && !blow_req_o));

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_DONE) |=> phase_o == PH_DONE);

  assert_locked_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && $past(lock_o) && phase_o == PH_INIT) |=> phase_o == PH_INIT);
endmodule

bind trim_prog_ctrl trim_prog_ctrl_chk #(.FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .high_i     (high_i),
  .blow_ack_i (blow_ack_i),
  .fuse_sens_i(fuse_sens_i),
  .sens_trim_o(sens_trim_o),
  .blow_req_o (blow_req_o),
  .blow_bit_o (blow_bit_o),
  .blow_err_o (blow_err_o),
  .lock_o     (lock_o),
  .phase_o    (phase_o)
);

// File: tb/trim_prog_ctrl_bench.sv
`timescale 1ns/1ps
module trim_prog_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mid = 1'b0, high = 1'b0, blow = 1'b0, ack = 1'b0;
  logic [5:0] fz_s = '0, fz_a = '0;
  logic       req, breg, lock, err;
  logic [2:0] bbit, phase;
  logic [5:0] sens;
  logic [4:0] qout;

  int n_tests = 0, n_fail = 0;
  int m_phase = 0, m_key = 0, m_code = 0, m_tgt = 0, m_has = 0, m_err = 0;
  bit chk_on = 1'b0;

  always #2.5 clk = ~clk;

  trim_prog_ctrl u_trim_prog_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mid_i(mid), .high_i(high), .blow_i(blow),
    .fuse_sens_i(fz_s), .fuse_aux_i(fz_a), .blow_ack_i(ack),
    .blow_req_o(req), .blow_reg_o(breg), .blow_bit_o(bbit),
    .sens_trim_o(sens), .qout_trim_o(qout), .lock_o(lock),
    .blow_err_o(err), .phase_o(phase)
  );

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bit_of(int v);
    for (int i = 0; i < 6; i++) if (v == (1 << i)) return i;
    return -1;
  endfunction

  // Behavioural reference: one step per rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_key = 0; m_code = 0; m_tgt = 0; m_has = 0; m_err = 0;
    end else begin
      automatic bit lk = fz_a[5];
      case (m_phase)
        0: if (!lk && high) begin m_phase = 1; m_key = 0; end
        1: if (!lk) begin
             if (high) begin
               if (m_key == 1 || m_key == 2) begin
                 m_tgt = m_key - 1; m_has = 1; m_code = 0; m_phase = 2;
               end else m_phase = 0;
             end else if (mid && m_key < 7) m_key++;
           end
        2: if (!lk) begin
             if (high) m_phase = 3;
             else if (mid && m_code < 63) m_code++;
           end
        3: if (!lk && blow) begin
             if (bit_of(m_code) >= 0) m_phase = 4;
             else begin m_err = 1; m_phase = 5; end
           end
        4: if (ack) begin
             if (m_tgt == 0) fz_s = fz_s | 6'(m_code);
             else            fz_a = fz_a | 6'(m_code);
             m_phase = 5;
           end
        default: ;
      endcase
    end
  end

  always @(posedge clk) begin
    #2;
    if (chk_on && rst_n) begin
      chk("R3 phase", int'(phase), m_phase);
      chk("R5 sens", int'(sens), int'(fz_s) | ((m_has && m_tgt == 0) ? m_code : 0));
      chk("R5 qout", int'(qout), (int'(fz_a) | ((m_has && m_tgt == 1) ? m_code : 0)) & 31);
      chk("R6 req", int'(req), int'(m_phase == 4));
      if (m_phase == 4) begin
        chk("R6 reg", int'(breg), m_tgt);
        chk("R6 bit", int'(bbit), bit_of(m_code));
      end
      chk("R7 err", int'(err), m_err);
      chk("R9 lock", int'(lock), int'(fz_a[5]));
    end
  end

  task automatic pulse(int kind);
    @(negedge clk);
    mid = (kind == 0); high = (kind == 1); blow = (kind == 2);
    @(negedge clk);
    mid = 1'b0; high = 1'b0; blow = 1'b0;
  endtask

  task automatic mids(int n);
    for (int i = 0; i < n; i++) pulse(0);
  endtask

  task automatic select_key(int k);
    pulse(1); mids(k); pulse(1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic give_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    chk_on = 1'b1;
    chk("R1 phase", int'(phase), 0);
    chk("R1 req", int'(req), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 sens", int'(sens), 0);
    mids(3); pulse(2);
    chk("R2 mid/blow ignored", int'(phase), 0);
    pulse(1);
    chk("R2 high to key", int'(phase), 1);
    mids(3); pulse(1);
    chk("R3 key 3 back to idle", int'(phase), 0);
    pulse(1); pulse(1);
    chk("R3 key 0 back to idle", int'(phase), 0);
    select_key(1);
    chk("R3 key 1 addressing", int'(phase), 2);
    mids(5);
    chk("R5 try sens", int'(sens), 5);
    mids(70);
    chk("R4 code saturates", int'(sens), 63);
    pulse(1);
    chk("R4 high arms", int'(phase), 3);
    pulse(0); pulse(1);
    chk("R6 armed ignores", int'(sens), 63);
    pulse(2);
    chk("R7 refused", int'(err), 1);
    chk("R7 no request", int'(req), 0);
    select_key(1); mids(2);
    chk("R8 done ignores", int'(phase), 5);
    chk("R8 try kept", int'(sens), 63);

    do_reset();
    chk("R1 err cleared", int'(err), 0);
    chk("R1 try dropped", int'(sens), 0);
    select_key(1); mids(4); pulse(1); pulse(2);
    repeat (3) @(negedge clk);
    chk("R6 req held", int'(req), 1);
    chk("R6 bit index", int'(bbit), 2);
    chk("R6 sens reg", int'(breg), 0);
    give_ack();
    chk("R6 done after ack", int'(phase), 5);
    do_reset();
    chk("R5 fuse survives reset", int'(sens), 4);
    select_key(1); mids(8); pulse(1); pulse(2); give_ack();
    do_reset();
    chk("R5 fuses accumulate", int'(sens), 12);

    select_key(2); mids(5);
    chk("R5 try qout", int'(qout), 5);
    chk("R5 sens untouched", int'(sens), 12);
    pulse(1); pulse(2);
    chk("R7 two bits refused", int'(err), 1);
    do_reset();
    select_key(2); mids(32); pulse(1); pulse(2);
    chk("R6 aux reg", int'(breg), 1);
    give_ack();
    do_reset();
    chk("R9 lock out", int'(lock), 1);
    chk("R9 qout no lock bit", int'(qout), 0);
    pulse(1); mids(1); pulse(1);
    chk("R9 locked ignores", int'(phase), 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule